// File: doc/BRIEF.md
# Programmable Pulse Generator Timer

A 16-bit up-counting timer that produces one pulse waveform from two compare values. A start is either a software command or a rising edge on an external pin. From the start, the counter advances on each prescaled count enable. When the counter reaches the width value, the output inverts and an interrupt strobe fires, and counting continues. When the counter reaches the period value, the output inverts again, the strobe fires and the counter returns to zero.

In continuous mode the cycle repeats until a stop command. In one-shot mode the running status clears itself at the period match. The pin always shows the inverse of an internal toggle flip-flop. That flip-flop resets to 0 and is reloaded from the initial-level bit only when the mode select goes from plain timer mode to pulse mode. A stop therefore freezes the pin at its current level.

Example: a period of 125 and a width of 25 counts give 125 counts per cycle. With the initial-level bit at 1, the first 25 counts are low and the last 100 are high.

Top module: `ppg_timer`

## Requirements
- R1: After reset, `pulse_o` is 1 (toggle flip-flop cleared), `irq_o` is 0 and `running_o` is 0.
- R2: After a start, the counter begins at 0. The tick that brings it to `width_i` inverts `pulse_o` and raises `irq_o` for one cycle, one clock after that tick. The count continues.
- R3: The tick that brings the counter to `period_i` inverts `pulse_o`, raises `irq_o` for one cycle and clears the counter. The cycle is therefore `period_i` ticks long, with the first phase `width_i` ticks long.
- R4: With `oneshot_i` = 0, pulses repeat, `running_o` stays 1 and the width and period strobes alternate.
- R5: With `oneshot_i` = 1, `running_o` drops in the same cycle as the period strobe. `pulse_o` then keeps its final level and no further strobe occurs.
- R6: `stop_i` clears `running_o` on the next clock. `pulse_o` holds the level it had just before, and no strobe follows.
- R7: When `pulse_mode_i` goes from 0 to 1, the flip-flop loads `init_lvl_i`, so `pulse_o` = NOT `init_lvl_i` on the next clock. At all other times a change of `init_lvl_i` has no effect on `pulse_o`.
- R8: With `start_sel_i` = 0, a one-cycle `sw_start_i` starts the timer (`running_o` = 1 on the next clock) and edges on `ext_start_i` are ignored. With `start_sel_i` = 1, `sw_start_i` is ignored.
- R9: With `start_sel_i` = 1, a rising edge on `ext_start_i` passes two synchroniser flops and starts the timer; `running_o` is 1 three clocks after the input rises. An edge is accepted only while the timer is stopped, and an edge during a run does not restart the count.
- R10: A compare value rewritten during a run is used at the next comparison.
- R11: The counter advances only in cycles where `cnt_en_i` = 1. With `cnt_en_i` held at 0, no strobe occurs.
- R12: `pulse_mode_i` = 0 stops the timer on the next clock, and `pulse_o` holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Prescaled count enable |
| pulse_mode_i | input | 1 | 1 = pulse mode, 0 = plain timer mode (idle) |
| start_sel_i | input | 1 | 0 = software start, 1 = external edge start |
| oneshot_i | input | 1 | 1 = stop after one period |
| init_lvl_i | input | 1 | Value loaded into the toggle flip-flop on entry to pulse mode |
| sw_start_i | input | 1 | Software start command |
| ext_start_i | input | 1 | Asynchronous external start pin |
| stop_i | input | 1 | Stop command |
| period_i | input | 16 | Period compare value |
| width_i | input | 16 | Width compare value (must be below `period_i`) |
| pulse_o | output | 1 | Pulse output, inverse of the toggle flip-flop |
| irq_o | output | 1 | One-cycle strobe on every output toggle |
| running_o | output | 1 | Run status |

## Verification
The toggle flip-flop is not visible at the ports. A wrong value there shows on `pulse_o` one clock after the event that should have set it, and the level stays wrong for the rest of the run. A corrupt counter shows as a wrong number of ticks between consecutive `irq_o` strobes, seen at the very next strobe. A stuck run flag shows either as strobes after a stop or one-shot end, or as missing strobes in continuous mode. The bench therefore measures tick counts between strobes and the pin level after each strobe, under both steady and random count enables.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
  typedef enum logic {
    START_SW  = 1'b0,
    START_EXT = 1'b1
  } start_src_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/ppg_edge_sync.sv
module ppg_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  localparam int unsigned LAST = STAGES;

  logic [LAST:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[LAST-1:0], async_i};
  end

  // sh_q[LAST-1] is the last synchroniser stage, sh_q[LAST] its delayed copy
  assign rise_o = sh_q[LAST-1] & ~sh_q[LAST];
endmodule

// File: rtl/ppg_counter.sv
module ppg_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             width_hit_o,
  output logic             period_hit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;
  logic             step;

  assign step   = run_i & tick_i;
  assign cnt_nx = cnt_q + 1'b1;

  // compare the value the counter is about to take
  assign period_hit_o = step & (cnt_nx == period_i);
  assign width_hit_o  = step & (cnt_nx == width_i) & ~period_hit_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step)    cnt_q <= period_hit_o ? '0 : cnt_nx;
  end
endmodule

// File: rtl/ppg_out.sv
module ppg_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic seed_i,
  input  logic lvl_i,
  input  logic toggle_i,
  output logic pulse_o
);
  logic tff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tff_q <= 1'b0;
    else if (seed_i)   tff_q <= lvl_i;
    else if (toggle_i) tff_q <= ~tff_q;
  end

  assign pulse_o = ~tff_q;
endmodule

// File: rtl/ppg_timer.sv
module ppg_timer
  import ppg_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic             pulse_mode_i,
  input  logic             start_sel_i,
  input  logic             oneshot_i,
  input  logic             init_lvl_i,
  input  logic             sw_start_i,
  input  logic             ext_start_i,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             pulse_o,
  output logic             irq_o,
  output logic             running_o
);
  logic mode_q;
  logic run_q;
  logic irq_q;
  logic seed;
  logic ext_rise;
  logic start_req;
  logic start_go;
  logic active;
  logic width_hit;
  logic period_hit;
  logic toggle;

  ppg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(ext_start_i),
    .rise_o (ext_rise)
  );

  // reseed only on an observed timer->pulse mode transition
  assign seed      = pulse_mode_i & ~mode_q;
  assign active    = run_q & pulse_mode_i & ~stop_i;
  assign start_req = (start_src_e'(start_sel_i) == START_EXT) ? ext_rise : sw_start_i;
  assign start_go  = ~run_q & pulse_mode_i & ~stop_i & start_req;
  assign toggle    = width_hit | period_hit;

  ppg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (start_go),
    .run_i       (active),
    .tick_i      (cnt_en_i),
    .period_i    (period_i),
    .width_i     (width_i),
    .width_hit_o (width_hit),
    .period_hit_o(period_hit)
  );

  ppg_out u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .seed_i  (seed),
    .lvl_i   (init_lvl_i),
    .toggle_i(toggle),
    .pulse_o (pulse_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b1;
      run_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      mode_q <= pulse_mode_i;
      irq_q  <= toggle;
      if (!pulse_mode_i || stop_i)      run_q <= 1'b0;
      else if (period_hit && oneshot_i) run_q <= 1'b0;
      else if (start_go)                run_q <= 1'b1;
    end
  end

  assign irq_o     = irq_q;
  assign running_o = run_q;
endmodule

// File: rtl/ppg_timer_chk.sv
module ppg_timer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pulse_mode_i,
  input logic oneshot_i,
  input logic stop_i,
  input logic init_lvl_i,
  input logic seed_i,
  input logic pulse_o,
  input logic irq_o,
  input logic running_o
);
  // R2
  pin_change_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pulse_o) |-> (irq_o || $past(seed_i)));

  // R3
  irq_needs_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(running_o));

  // R4
  cont_keeps_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !$past(oneshot_i) && !$past(stop_i) && $past(pulse_mode_i)) |-> running_o);

  // R5
  run_fall_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(running_o) |-> ($past(stop_i) || !$past(pulse_mode_i) || (irq_o && $past(oneshot_i))));

  // R6
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(stop_i) && !$past(seed_i)) |-> $stable(pulse_o));

  // R7
  seed_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(seed_i) |-> (pulse_o == !$past(init_lvl_i)));

  // R12
  mode_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_mode_i |=> !running_o);

  // R8
  start_in_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(running_o) |-> ($past(pulse_mode_i) && !$past(stop_i)));
endmodule

bind ppg_timer ppg_timer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pulse_mode_i(pulse_mode_i),
  .oneshot_i   (oneshot_i),
  .stop_i      (stop_i),
  .init_lvl_i  (init_lvl_i),
  .seed_i      (seed),
  .pulse_o     (pulse_o),
  .irq_o       (irq_o),
  .running_o   (running_o)
);

// File: tb/sim_ppg_timer.sv
module sim_ppg_timer;
  localparam int CW = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          cnt_en = 1'b1;
  logic          mode = 1'b1;
  logic          sel = 1'b0;
  logic          oneshot = 1'b0;
  logic          init_lvl = 1'b0;
  logic          sw_start = 1'b0;
  logic          ext_start = 1'b0;
  logic          stop = 1'b0;
  logic [CW-1:0] period = 16'd10;
  logic [CW-1:0] width = 16'd3;
  logic          pulse, irq, running;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  ppg_timer #(.CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(cnt_en), .pulse_mode_i(mode),
    .start_sel_i(sel), .oneshot_i(oneshot), .init_lvl_i(init_lvl),
    .sw_start_i(sw_start), .ext_start_i(ext_start), .stop_i(stop),
    .period_i(period), .width_i(width),
    .pulse_o(pulse), .irq_o(irq), .running_o(running)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // counts ticks applied until the next strobe is seen
  task automatic wait_irq(input bit rnd, output int ticks);
    ticks = 0;
    for (int i = 0; i < 5000; i++) begin
      cnt_en = rnd ? 1'($urandom % 2) : 1'b1;
      if (cnt_en) ticks++;
      @(negedge clk);
      if (irq) return;
    end
    ticks = -1;
  endtask

  task automatic do_sw_start();
    sw_start = 1'b1;
    step(1);
    sw_start = 1'b0;
  endtask

  task automatic do_stop();
    stop = 1'b1;
    step(1);
    stop = 1'b0;
  endtask

  task automatic do_seed(input logic lvl);
    mode = 1'b0;
    step(1);
    init_lvl = lvl;
    mode = 1'b1;
    step(1);
  endtask

  // quiet window: no strobe, pin fixed, run stays at exp_run
  task automatic quiet(input string req, input int n, input logic exp_pin, input logic exp_run);
    int bad;
    bad = 0;
    for (int i = 0; i < n; i++) begin
      step(1);
      if (irq || pulse !== exp_pin || running !== exp_run) bad++;
    end
    chk(req, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int t;
    void'($urandom(32'd1337));
    step(3);
    // R1
    chk("R1 pulse", pulse, 1);
    chk("R1 irq", irq, 0);
    chk("R1 running", running, 0);
    rst_n = 1'b1;
    step(2);

    // R7 seed and ignore
    do_seed(1'b1);
    chk("R7 seed 1", pulse, 0);
    init_lvl = 1'b0;
    step(3);
    chk("R7 init ignored", pulse, 0);

    // R8, R2, R3, R4 continuous P=10 W=3
    do_sw_start();
    chk("R8 sw start", running, 1);
    wait_irq(0, t); chk("R2 width ticks", t, 3); chk("R2 pin", pulse, 1);
    wait_irq(0, t); chk("R3 period ticks", t, 7); chk("R3 pin", pulse, 0);
    wait_irq(0, t); chk("R4 width again", t, 3);
    wait_irq(0, t); chk("R4 period again", t, 7); chk("R4 running", running, 1);

    // R10 live rewrite
    wait_irq(0, t);
    period = 16'd20;
    wait_irq(0, t); chk("R10 new period", t, 17);
    period = 16'd10;
    wait_irq(0, t); chk("R10 width", t, 3);
    wait_irq(0, t); chk("R10 restored", t, 7);

    // R6 stop holds level
    wait_irq(0, t);
    chk("R6 pin before stop", pulse, 1);
    do_stop();
    chk("R6 running", running, 0);
    quiet("R6 hold", 30, 1'b1, 1'b0);

    // R12 leave pulse mode
    do_seed(1'b0);
    chk("R7 seed 0", pulse, 1);
    do_sw_start();
    wait_irq(0, t); chk("R12 width", t, 3); chk("R12 pin", pulse, 0);
    mode = 1'b0;
    step(1);
    chk("R12 running", running, 0);
    quiet("R12 hold", 5, 1'b0, 1'b0);
    mode = 1'b1;
    step(1);
    chk("R7 reseed", pulse, 1);

    // R5 one-shot P=6 W=2
    oneshot = 1'b1; period = 16'd6; width = 16'd2;
    do_sw_start();
    wait_irq(0, t); chk("R5 width", t, 2); chk("R5 pin mid", pulse, 0);
    wait_irq(0, t); chk("R5 period", t, 4); chk("R5 running", running, 0);
    chk("R5 pin end", pulse, 1);
    quiet("R5 stays", 20, 1'b1, 1'b0);
    oneshot = 1'b0;

    // R8 ext ignored with software select
    ext_start = 1'b1;
    step(5);
    chk("R8 ext ignored", running, 0);
    ext_start = 1'b0;
    step(3);

    // R9 external start
    sel = 1'b1;
    do_sw_start();
    chk("R8 sw ignored", running, 0);
    step(2);
    ext_start = 1'b1;
    step(2);
    chk("R9 sync delay", running, 0);
    step(1);
    chk("R9 ext start", running, 1);
    wait_irq(0, t); chk("R9 width", t, 2);
    cnt_en = 1'b0;
    ext_start = 1'b0;
    step(3);
    ext_start = 1'b1;
    step(4);
    wait_irq(0, t); chk("R9 no restart", t, 4);
    do_stop();
    ext_start = 1'b0;
    sel = 1'b0;
    step(3);

    // R11 enable held low
    cnt_en = 1'b0;
    do_sw_start();
    quiet("R11 no tick", 40, pulse, 1'b1);
    do_stop();

    // R11 random enables, random compares
    for (int k = 0; k < 4; k++) begin
      width = CW'(1 + $urandom % 20);
      period = width + CW'(1 + $urandom % 30);
      do_sw_start();
      wait_irq(1, t); chk("R11 rnd width", t, int'(width));
      wait_irq(1, t); chk("R11 rnd period", t, int'(period - width));
      do_stop();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule